// File: doc/BRIEF.md
# Quadrant-Symmetric Quadrature NCO

This block is a numerically controlled oscillator that produces a cosine (I) and a sine (Q) sample on every enabled clock. A 32-bit phase accumulator integrates a programmable increment. The increment may be rewritten at any time, so the block can serve frequency modulation and phase-step modulation as well as fixed-tone generation. The ten upper accumulator bits form a binary-angle phase word. Its top two bits name one of four quadrants, and the eight bits below them index a table that holds only a quarter of a sine wave.

Two lookups of that quarter-wave table run in parallel, one for each output. In each quadrant, every lookup either uses the index as it is or reflects it. The looked-up magnitude is then negated or passed through, depending on the quadrant. The table is filled at elaboration by a fixed-point series evaluated in a constant function, so the block needs no memory-initialisation file. Each table entry is sampled at the middle of its phase bin. Because of this, a reflected index lands on an exact mirror angle, and neither output ever reaches zero or full negative scale.

Both outputs take three clocks to produce: table read, sign stage and output register. A valid flag travels with them. A synchronous reset clears the accumulator and the pipeline.

Top module: `nco_quad_top`

## Requirements
- R1: On every clock edge with `en` high and `rst` low, the accumulator advances by `phase_inc` (modulo 2^32). A changed `phase_inc` is used from the next enabled edge on, and the accumulated phase carries on with no jump.
- R2: While `en` is low, the accumulator holds its value and no output sample is marked valid. When `en` returns high, the phase resumes from the held value.
- R3: The phase word of a sample is accumulator bits [31:22], taken before the edge that adds the increment. Bit 31 weighs π, so phase word p stands for the angle 2π·(p+0.5)/1024.
- R4: For phase word p, `out_q` equals round(32767·sin θ) and `out_i` equals round(32767·cos θ), within ±1 LSB, in two's complement.
- R5: Both outputs come from one quarter-wave magnitude table. The sine index runs forward in quadrants 0 and 2 and reversed in quadrants 1 and 3, and the cosine index does the opposite. Consequences: Q(p) = Q(511−p) and I(p) = Q(255−p) for p < 256, and Q(p+512) = −Q(p).
- R6: `out_q` is negative exactly when phase bit 9 is 1. `out_i` is negative exactly when phase bits 9 and 8 differ.
- R7: A sample launched at an enabled edge appears, with `out_valid` high, after the third clock edge counting that one. `out_valid` is high for exactly one cycle per enabled edge.
- R8: `rst` high at a clock edge clears the accumulator to 0, and clears `out_valid`, `out_i` and `out_q` to 0. The first sample after reset has phase word 0: `out_i` = 32767 and `out_q` = 101.
- R9: Neither output ever takes the value −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and launch a sample |
| phase_inc | input | 32 | Phase increment per sample, binary angle |
| out_i | output | 16 | Signed cosine sample |
| out_q | output | 16 | Signed sine sample |
| out_valid | output | 1 | Sample on `out_i`/`out_q` is valid |

## Verification
A sweep that steps exactly one phase word per sample visits all 1024 phases, so every table entry is read under both forward and reversed indexing and under both signs. This sweep separates mistakes in address reflection from mistakes in sign selection. A half-cycle increment alternates between only two phases, and a negative increment walks the phase backwards through quadrant boundaries. A small odd increment shows that carries from the lower accumulator bits reach the phase word. The increment is changed with no reset in between, `en` is gapped, and reset is applied mid-stream. Together these show that a new increment takes effect on the next clock, that phase is held and then resumed, and that the pipeline and accumulator are flushed.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        QD_RISE  = 2'b00,
        QD_FALL  = 2'b01,
        QD_DROP  = 2'b10,
        QD_CLIMB = 2'b11
    } quad_e;

    // Quarter-wave sine magnitude at bin centre: angle = (2*idx+1)*pi / 2^(aw+2)
    // Odd Taylor series to x^11 in Q28 fixed point, nested (Horner) form.
    function automatic longint qw_sine(input int idx, input int aw, input int dw);
        longint one;
        longint pi_q;
        longint x;
        longint x2;
        longint t;
        longint s;
        longint amp;
        one  = 64'sd1 <<< 28;
        pi_q = 64'sd843314857;
        x    = (pi_q * longint'(2 * idx + 1)) >>> (aw + 2);
        x2   = (x * x) >>> 28;
        t    = one - x2 / 110;
        t    = one - ((x2 * t) >>> 28) / 72;
        t    = one - ((x2 * t) >>> 28) / 42;
        t    = one - ((x2 * t) >>> 28) / 20;
        t    = one - ((x2 * t) >>> 28) / 6;
        s    = (x * t) >>> 28;
        amp  = (64'sd1 <<< (dw - 1)) - 1;
        return (s * amp + (one >>> 1)) >>> 28;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + inc;
        end
    end

    // R1: enabled edge advances by the increment seen at that edge
    a_r1_acc_step: assert property (@(posedge clk) disable iff (rst)
        en |=> acc == $past(acc) + $past(inc));

    // R2: disabled edge leaves the phase untouched
    a_r2_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

endmodule

// File: rtl/nco_fold.sv
module nco_fold #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        quad,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] sin_addr,
    output logic [ADDR_W-1:0] cos_addr,
    output logic              sin_neg,
    output logic              cos_neg
);
    import nco_pkg::*;

    always_comb begin
        unique case (quad_e'(quad))
            QD_RISE: begin
                sin_addr = addr;   cos_addr = ~addr;
                sin_neg  = 1'b0;   cos_neg  = 1'b0;
            end
            QD_FALL: begin
                sin_addr = ~addr;  cos_addr = addr;
                sin_neg  = 1'b0;   cos_neg  = 1'b1;
            end
            QD_DROP: begin
                sin_addr = addr;   cos_addr = ~addr;
                sin_neg  = 1'b1;   cos_neg  = 1'b1;
            end
            QD_CLIMB: begin
                sin_addr = ~addr;  cos_addr = addr;
                sin_neg  = 1'b1;   cos_neg  = 1'b0;
            end
            default: begin
                sin_addr = addr;   cos_addr = ~addr;
                sin_neg  = 1'b0;   cos_neg  = 1'b0;
            end
        endcase
    end

    // R5: the two lookups always use complementary reflections
    always_comb begin
        a_r5_mirror_pair: assert ((sin_addr ^ cos_addr) == {ADDR_W{1'b1}});
    end

endmodule

// File: rtl/nco_qrom.sv
module nco_qrom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        assign tbl[k] = DATA_W'(nco_pkg::qw_sine(k, ADDR_W, DATA_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (rd_en) begin
            dout <= tbl[addr];
        end
    end

    // R9: every magnitude read is strictly positive and below full scale
    a_r9_entry_range: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (dout != '0) && !dout[DATA_W-1]);

endmodule

// File: rtl/nco_quad_top.sv
module nco_quad_top #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 8,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        phase_inc,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    out_valid
);
    localparam int PH_W = ADDR_W + 2;
    localparam logic signed [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

    logic [ACC_W-1:0]  acc;
    logic [PH_W-1:0]   ph;
    logic [ADDR_W-1:0] sin_a, cos_a;
    logic              sin_n, cos_n;
    logic [OUT_W-1:0]  mag_i, mag_q;

    // stage registers
    logic                    s1_v, s1_sneg, s1_cneg;
    logic [1:0]              s1_quad;
    logic                    s2_v;
    logic [1:0]              s2_quad;
    logic signed [OUT_W-1:0] s2_i, s2_q;
    logic [1:0]              s3_quad;

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .en(en), .inc(phase_inc), .acc(acc)
    );

    assign ph = acc[ACC_W-1 -: PH_W];

    nco_fold #(.ADDR_W(ADDR_W)) u_fold (
        .quad(ph[PH_W-1 -: 2]), .addr(ph[ADDR_W-1:0]),
        .sin_addr(sin_a), .cos_addr(cos_a),
        .sin_neg(sin_n), .cos_neg(cos_n)
    );

    nco_qrom #(.ADDR_W(ADDR_W), .DATA_W(OUT_W)) u_rom_i (
        .clk(clk), .rst(rst), .rd_en(en), .addr(cos_a), .dout(mag_i)
    );

    nco_qrom #(.ADDR_W(ADDR_W), .DATA_W(OUT_W)) u_rom_q (
        .clk(clk), .rst(rst), .rd_en(en), .addr(sin_a), .dout(mag_q)
    );

    // stage 1: table read alongside sign controls
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v    <= 1'b0;
            s1_sneg <= 1'b0;
            s1_cneg <= 1'b0;
            s1_quad <= '0;
        end else begin
            s1_v <= en;
            if (en) begin
                s1_sneg <= sin_n;
                s1_cneg <= cos_n;
                s1_quad <= ph[PH_W-1 -: 2];
            end
        end
    end

    // stage 2: sign restoration
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v    <= 1'b0;
            s2_i    <= '0;
            s2_q    <= '0;
            s2_quad <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_quad <= s1_quad;
            s2_i    <= s1_cneg ? -$signed(mag_i) : $signed(mag_i);
            s2_q    <= s1_sneg ? -$signed(mag_q) : $signed(mag_q);
        end
    end

    // stage 3: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            s3_quad   <= '0;
        end else begin
            out_valid <= s2_v;
            s3_quad   <= s2_quad;
            if (s2_v) begin
                out_i <= s2_i;
                out_q <= s2_q;
            end
        end
    end

    // R7: fixed three-edge latency, one valid per enabled edge
    a_r7_launch: assert property (@(posedge clk) disable iff (rst)
        en |-> ##3 out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !en |-> ##3 !out_valid);

    // R6: sign of each output follows its quadrant
    a_r6_sin_sign: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_q[OUT_W-1] == s3_quad[1]);
    a_r6_cos_sign: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_i[OUT_W-1] == (s3_quad[1] ^ s3_quad[0]));

    // R9: full negative scale never produced
    a_r9_no_neg_full: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_i != NEG_FULL) && (out_q != NEG_FULL));

endmodule

// File: tb/sim_nco_quad_top.sv
module sim_nco_quad_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en = 1'b0;
    logic [31:0]        phase_inc = '0;
    logic signed [15:0] out_i, out_q;
    logic               out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    logic [31:0] m_acc = '0;
    bit          p_v  [3];
    int          p_ph [3];
    int          cap_i [1024];
    int          cap_q [1024];
    int          valid_seen = 0;

    localparam int NVEC = 5;
    localparam logic [31:0] V_INC [NVEC] = '{
        32'h0040_0000,   // one phase word per sample: full sweep
        32'h1000_0000,   // sixteenth of a cycle
        32'h8000_0000,   // half cycle: two phases alternate
        32'hFFC0_0000,   // one word backwards
        32'h0012_3457    // small odd step: lower-bit carries
    };
    localparam int V_LEN [NVEC] = '{1030, 40, 20, 1030, 300};

    nco_quad_top u0 (
        .clk(clk), .rst(rst), .en(en), .phase_inc(phase_inc),
        .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    always #4 clk = ~clk;

    function automatic int exp_val(input int p, input bit want_sin);
        real th;
        real r;
        th = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0;
        r  = 32767.0 * (want_sin ? $sin(th) : $cos(th));
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit near(input int a, input int b);
        return (a - b <= 1) && (b - a <= 1);
    endfunction

    task automatic check_out();
        int ei, eq, p;
        check(out_valid === p_v[2], "R7 valid timing", int'(out_valid), int'(p_v[2]));
        if (out_valid) valid_seen++;
        if (p_v[2] && out_valid) begin
            p  = p_ph[2];
            ei = exp_val(p, 1'b0);
            eq = exp_val(p, 1'b1);
            cap_i[p] = int'(out_i);
            cap_q[p] = int'(out_q);
            check(near(int'(out_q), eq), "R1 R3 R4 sine value", int'(out_q), eq);
            check(near(int'(out_i), ei), "R1 R3 R4 cosine value", int'(out_i), ei);
            check(out_q[15] == p[9], "R6 sine sign", int'(out_q[15]), p[9]);
            check(out_i[15] == (p[9] ^ p[8]), "R6 cosine sign", int'(out_i[15]), p[9] ^ p[8]);
            check((out_i != -16'sd32768) && (out_q != -16'sd32768), "R9 no full negative",
                  int'(out_q), eq);
        end
    endtask

    // one clock: drive at negedge, model at posedge, observe at next negedge
    task automatic cycle(input bit e, input logic [31:0] inc, input bit r);
        en = e;
        phase_inc = inc;
        rst = r;
        @(posedge clk);
        if (r) begin
            m_acc = '0;
            for (int k = 0; k < 3; k++) p_v[k] = 1'b0;
        end else begin
            p_v[2] = p_v[1];  p_ph[2] = p_ph[1];
            p_v[1] = p_v[0];  p_ph[1] = p_ph[0];
            p_v[0] = e;       p_ph[0] = int'(m_acc[31:22]);
            if (e) m_acc = m_acc + inc;
        end
        @(negedge clk);
        if (!r) check_out();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int mis;
        for (int k = 0; k < 3; k++) begin p_v[k] = 1'b0; p_ph[k] = 0; end
        @(negedge clk);
        for (int k = 0; k < 3; k++) cycle(1'b1, 32'h0400_0000, 1'b1);

        // R8 reset state
        check(out_valid === 1'b0, "R8 reset valid", int'(out_valid), 0);
        check(out_i === 16'sd0, "R8 reset out_i", int'(out_i), 0);
        check(out_q === 16'sd0, "R8 reset out_q", int'(out_q), 0);

        // vector table, increments changed on the fly (R1)
        for (int v = 0; v < NVEC; v++) begin
            for (int n = 0; n < V_LEN[v]; n++) cycle(1'b1, V_INC[v], 1'b0);
        end

        // R5 symmetry over phases captured during the sweeps
        mis = 0;
        for (int p = 0; p < 256; p++) if (cap_q[p] != cap_q[511 - p]) mis++;
        check(mis == 0, "R5 sine reflection", mis, 0);
        mis = 0;
        for (int p = 0; p < 256; p++) if (cap_i[p] != cap_q[255 - p]) mis++;
        check(mis == 0, "R5 cosine from reversed index", mis, 0);
        mis = 0;
        for (int p = 0; p < 512; p++) if (cap_q[p + 512] != -cap_q[p]) mis++;
        check(mis == 0, "R5 sine half-cycle negation", mis, 0);

        // R2: gapped enable, hold and resume
        for (int n = 0; n < 3; n++) cycle(1'b0, 32'h0400_0000, 1'b0);
        valid_seen = 0;
        for (int n = 0; n < 6; n++) cycle(1'b0, 32'h0400_0000, 1'b0);
        check(valid_seen == 0, "R2 no valid while disabled", valid_seen, 0);
        for (int n = 0; n < 24; n++) cycle(n % 3 == 0, 32'h0400_0000, 1'b0);
        for (int n = 0; n < 3; n++) cycle(1'b0, 32'h0400_0000, 1'b0);

        // R8: reset mid-stream
        for (int n = 0; n < 10; n++) cycle(1'b1, 32'h0700_0000, 1'b0);
        cycle(1'b1, 32'h0700_0000, 1'b1);
        check(out_valid === 1'b0, "R8 valid cleared by reset", int'(out_valid), 0);
        cycle(1'b1, 32'h0700_0000, 1'b0);
        cycle(1'b1, 32'h0700_0000, 1'b0);
        cycle(1'b1, 32'h0700_0000, 1'b0);
        check(out_valid === 1'b1, "R8 first valid after reset", int'(out_valid), 1);
        check(out_i == 16'sd32767, "R8 first cosine after reset", int'(out_i), 32767);
        check(out_q == 16'sd101, "R8 first sine after reset", int'(out_q), 101);
        for (int n = 0; n < 6; n++) cycle(1'b1, 32'h0700_0000, 1'b0);
        for (int n = 0; n < 3; n++) cycle(1'b0, 32'h0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule